// File: doc/BRIEF.md
# Power-up reset time-out sequencer

This block decides when a small microcontroller core may leave reset. A clean power-on pulse (`por`) clears it. After that it runs two delays in sequence. The first is a power-up delay, counted on a slow internal RC clock; a configuration input can disable it. The second is an oscillator settling count on the main oscillator clock. The second delay applies only when the oscillator is a crystal or resonator. The core reset output drops only when both delays are finished and the external master-clear pin is high.

The delays are timed from the power-on pulse and not from master-clear. If a board holds master-clear low past both delays, the core starts as soon as the pin rises. A wake-up from sleep in a crystal mode re-runs only the oscillator settling count. In RC modes a wake-up adds no delay. Both delay lengths are parameters, so a simulation can shorten them.

Each release of the core reset produces a one-cycle `done_pulse` in the oscillator clock domain.

Top module: `rst_timeout_seq`

## Requirements
- R1: While `por` is high, `core_rst` is 1 and `done_pulse` is 0.
- R2: With `pwrt_en` = 1, `core_rst` stays high for at least PWRT_CYCLES-1 periods of `clk_rc` after `por` falls.
- R3: In the crystal modes (`osc_mode` 2'b00, 2'b01 and 2'b10), the power-up delay is followed by OST_CYCLES `clk_osc` cycles of further reset hold, then the release.
- R4: In RC mode (`osc_mode` = 2'b11) there is no oscillator count. With the power-up delay enabled, reset releases within a few oscillator cycles after that delay ends.
- R5: With `pwrt_en` = 0 the power-up delay is skipped. RC mode then releases within one RC period plus a few oscillator cycles. Crystal modes release after only the oscillator count.
- R6: A one-cycle `wake_evt` while running in a crystal mode sets `core_rst` on the second `clk_osc` edge. It holds `core_rst` high for exactly OST_CYCLES cycles, with no power-up delay.
- R7: `wake_evt` in RC mode has no effect. `core_rst` stays low and `done_pulse` stays 0.
- R8: After `mclr_n` has been low for 3 oscillator edges, `core_rst` is high. A rise of `mclr_n` after the delays have expired releases the core on the third `clk_osc` edge, without re-running any delay.
- R9: `done_pulse` is high for exactly one cycle per release. That cycle is the first cycle in which `core_rst` is low.
- R10: The core is never released before the power-up delay has finished, and the oscillator count never exceeds OST_CYCLES-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Main oscillator clock |
| clk_rc | input | 1 | Internal RC clock for the power-up delay |
| por | input | 1 | Power-on reset pulse, active high, asynchronous |
| mclr_n | input | 1 | External master clear, active low, asynchronous |
| wake_evt | input | 1 | Sleep wake-up event, one `clk_osc` cycle |
| pwrt_en | input | 1 | Enables the power-up delay |
| osc_mode | input | 2 | 00/01/10 crystal or resonator modes, 11 RC mode |
| core_rst | output | 1 | Core reset hold, active high |
| done_pulse | output | 1 | One-cycle pulse when the core leaves reset |

## Verification
A `mclr_n` edge reaches `core_rst` on the third `clk_osc` edge: two synchronizer flops, then the registered reset. The bench drives the pin at a falling edge and samples after the second and third rising edges. A wake-up sampled at edge E gives `core_rst` high from E+1 through E+OST_CYCLES. The bench therefore counts exactly OST_CYCLES high samples and expects `done_pulse` in the first low sample. The power-up delay crosses clock domains, so its release is checked inside a window of one RC period plus a few synchronizer cycles. That window is narrow enough to catch a wrong delay length or a skipped oscillator count.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [1:0] {
        ST_PWRT = 2'd0,
        ST_OST  = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_e;

    localparam logic [1:0] MODE_RC = 2'b11;

    // crystal/resonator modes need the oscillator settling count
    function automatic logic mode_needs_ost(input logic [1:0] mode);
        return mode != MODE_RC;
    endfunction

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_comb chain_d[i] = d;
            end else begin : g_next
                always_comb chain_d[i] = chain_q[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or posedge rst) begin
        if (rst) chain_q <= {STAGES{RST_VAL}};
        else     chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rst_pwrt_timer.sv
module rst_pwrt_timer #(
    parameter int PWRT_CYCLES = 2304
) (
    input  logic clk_rc,
    input  logic por,
    input  logic pwrt_en,
    output logic pwrt_done
);
    localparam int CW = $clog2(PWRT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(PWRT_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } pwrt_reg_t;

    pwrt_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!r_q.done) begin
            if (!pwrt_en) begin
                r_d.done = 1'b1;
            end else if (r_q.cnt == LAST) begin
                r_d.done = 1'b1;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_rc or posedge por) begin
        if (por) r_q <= '0;
        else     r_q <= r_d;
    end

    assign pwrt_done = r_q.done;
endmodule

// File: rtl/rst_ost_seq.sv
module rst_ost_seq
    import rst_seq_pkg::*;
#(
    parameter int OST_CYCLES = 1024,
    parameter int CW         = $clog2(OST_CYCLES + 1)
) (
    input  logic          clk_osc,
    input  logic          por,
    input  logic          pwrt_seen,
    input  logic          wake_evt,
    input  logic [1:0]    osc_mode,
    input  logic          mclr_ok,
    output logic          core_rst,
    output logic          done_pulse,
    output logic [CW-1:0] ost_count
);
    localparam logic [CW-1:0] LAST = CW'(OST_CYCLES - 1);

    typedef struct packed {
        seq_state_e    state;
        logic [CW-1:0] cnt;
        logic          rst;
        logic          pulse;
    } ost_reg_t;

    ost_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_PWRT: begin
                if (pwrt_seen) begin
                    r_d.cnt = '0;
                    r_d.state = mode_needs_ost(osc_mode) ? ST_OST : ST_RUN;
                end
            end
            ST_OST: begin
                if (r_q.cnt == LAST) r_d.state = ST_RUN;
                else                 r_d.cnt = r_q.cnt + 1'b1;
            end
            ST_RUN: begin
                if (wake_evt && mode_needs_ost(osc_mode)) begin
                    r_d.state = ST_OST;
                    r_d.cnt   = '0;
                end
            end
            default: r_d.state = ST_PWRT;
        endcase
        r_d.rst   = !((r_q.state == ST_RUN) && mclr_ok);
        r_d.pulse = r_q.rst && !r_d.rst;
    end

    always_ff @(posedge clk_osc or posedge por) begin
        if (por) begin
            r_q.state <= ST_PWRT;
            r_q.cnt   <= '0;
            r_q.rst   <= 1'b1;
            r_q.pulse <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign core_rst   = r_q.rst;
    assign done_pulse = r_q.pulse;
    assign ost_count  = r_q.cnt;
endmodule

// File: rtl/rst_timeout_seq.sv
module rst_timeout_seq #(
    parameter int PWRT_CYCLES = 2304,
    parameter int OST_CYCLES  = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_osc,
    input  logic       clk_rc,
    input  logic       por,
    input  logic       mclr_n,
    input  logic       wake_evt,
    input  logic       pwrt_en,
    input  logic [1:0] osc_mode,
    output logic       core_rst,
    output logic       done_pulse
);
    localparam int OCW = $clog2(OST_CYCLES + 1);

    logic            pwrt_done_rc;
    logic            pwrt_seen;
    logic            mclr_ok;
    logic [OCW-1:0]  ost_count;

    rst_pwrt_timer #(.PWRT_CYCLES(PWRT_CYCLES)) u_pwrt (
        .clk_rc    (clk_rc),
        .por       (por),
        .pwrt_en   (pwrt_en),
        .pwrt_done (pwrt_done_rc)
    );

    rst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_pwrt (
        .clk (clk_osc),
        .rst (por),
        .d   (pwrt_done_rc),
        .q   (pwrt_seen)
    );

    rst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mclr (
        .clk (clk_osc),
        .rst (por),
        .d   (mclr_n),
        .q   (mclr_ok)
    );

    rst_ost_seq #(.OST_CYCLES(OST_CYCLES), .CW(OCW)) u_ost (
        .clk_osc    (clk_osc),
        .por        (por),
        .pwrt_seen  (pwrt_seen),
        .wake_evt   (wake_evt),
        .osc_mode   (osc_mode),
        .mclr_ok    (mclr_ok),
        .core_rst   (core_rst),
        .done_pulse (done_pulse),
        .ost_count  (ost_count)
    );
endmodule

// File: rtl/rst_timeout_seq_chk.sv
module rst_timeout_seq_chk #(
    parameter int OST_CYCLES = 1024,
    parameter int CW         = 11
) (
    input logic          clk_osc,
    input logic          por,
    input logic          mclr_n,
    input logic          wake_evt,
    input logic [1:0]    osc_mode,
    input logic          core_rst,
    input logic          done_pulse,
    input logic          pwrt_seen,
    input logic [CW-1:0] ost_count
);
    // R9
    pulse_when_released_chk: assert property (@(posedge clk_osc) disable iff (por)
        done_pulse |-> !core_rst);

    // R9
    pulse_single_cycle_chk: assert property (@(posedge clk_osc) disable iff (por)
        done_pulse |=> !done_pulse);

    // R8
    mclr_holds_reset_chk: assert property (@(posedge clk_osc) disable iff (por)
        (!mclr_n && $past(!mclr_n) && $past(!mclr_n, 2) && $past(!mclr_n, 3)) |-> core_rst);

    // R10
    release_after_pwrt_chk: assert property (@(posedge clk_osc) disable iff (por)
        !core_rst |-> pwrt_seen);

    // R10
    ost_count_bound_chk: assert property (@(posedge clk_osc) disable iff (por)
        ost_count < CW'(OST_CYCLES));

    // R6
    xtal_wake_holds_chk: assert property (@(posedge clk_osc) disable iff (por)
        (wake_evt && osc_mode != 2'b11 && !core_rst) |=> ##1 core_rst);
endmodule

bind rst_timeout_seq rst_timeout_seq_chk #(.OST_CYCLES(OST_CYCLES), .CW(OCW)) u_chk (
    .clk_osc    (clk_osc),
    .por        (por),
    .mclr_n     (mclr_n),
    .wake_evt   (wake_evt),
    .osc_mode   (osc_mode),
    .core_rst   (core_rst),
    .done_pulse (done_pulse),
    .pwrt_seen  (pwrt_seen),
    .ost_count  (ost_count)
);

// File: tb/tb_rst_timeout_seq.sv
`timescale 1ns/1ps
module tb_rst_timeout_seq;
    localparam int PWRT   = 40;
    localparam int OST    = 64;
    localparam int RC_DIV = 8;   // RC period in oscillator periods

    logic       clk_osc = 1'b0;
    logic       clk_rc  = 1'b0;
    logic       por     = 1'b1;
    logic       mclr_n  = 1'b1;
    logic       wake_evt = 1'b0;
    logic       pwrt_en = 1'b1;
    logic [1:0] osc_mode = 2'b01;
    logic       core_rst, done_pulse;

    int checks = 0;
    int errors = 0;

    always #2 clk_osc = ~clk_osc;                 // 250 MHz
    always #(2 * RC_DIV) clk_rc = ~clk_rc;

    rst_timeout_seq #(.PWRT_CYCLES(PWRT), .OST_CYCLES(OST)) dut (
        .clk_osc (clk_osc), .clk_rc (clk_rc), .por (por), .mclr_n (mclr_n),
        .wake_evt (wake_evt), .pwrt_en (pwrt_en), .osc_mode (osc_mode),
        .core_rst (core_rst), .done_pulse (done_pulse)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // power-on with given config; returns oscillator cycles until core_rst low
    task automatic power_up(input logic [1:0] mode, input logic en, input logic mclr,
                            output int cyc);
        @(negedge clk_osc);
        por = 1'b1; osc_mode = mode; pwrt_en = en; mclr_n = mclr;
        repeat (4) @(negedge clk_osc);
        chk(core_rst == 1'b1, "R1 core_rst during por", core_rst, 1);
        chk(done_pulse == 1'b0, "R1 done_pulse during por", done_pulse, 0);
        por = 1'b0;
        cyc = 0;
        while (core_rst && cyc < 3000) begin
            @(negedge clk_osc);
            if (core_rst) cyc++;
        end
    endtask

    task automatic test_xtal_pwrt();
        int c;
        int lo = (PWRT - 1) * RC_DIV + OST;
        int hi = PWRT * RC_DIV + OST + 8;
        power_up(2'b01, 1'b1, 1'b1, c);
        chk(c >= lo, "R2 R3 xtal release not early", c, lo);
        chk(c <= hi, "R3 xtal release not late", c, hi);
        chk(done_pulse == 1'b1, "R9 pulse at release", done_pulse, 1);
        @(negedge clk_osc);
        chk(done_pulse == 1'b0, "R9 pulse one cycle", done_pulse, 0);
    endtask

    task automatic test_rc_pwrt();
        int c;
        int lo = (PWRT - 1) * RC_DIV;
        int hi = PWRT * RC_DIV + 8;
        power_up(2'b11, 1'b1, 1'b1, c);
        chk(c >= lo, "R2 rc release not early", c, lo);
        chk(c <= hi, "R4 rc release without oscillator count", c, hi);
    endtask

    task automatic test_xtal_nopwrt();
        int c;
        power_up(2'b10, 1'b0, 1'b1, c);
        chk(c >= OST, "R5 xtal no pwrt not early", c, OST);
        chk(c <= OST + RC_DIV + 8, "R5 xtal no pwrt only oscillator count", c, OST + RC_DIV + 8);
    endtask

    task automatic test_rc_nopwrt();
        int c;
        power_up(2'b11, 1'b0, 1'b1, c);
        chk(c <= RC_DIV + 8, "R5 rc no pwrt immediate", c, RC_DIV + 8);
    endtask

    task automatic test_wake_xtal();
        int c;
        int hi_cnt = 0;
        power_up(2'b00, 1'b1, 1'b1, c);
        repeat (5) @(negedge clk_osc);
        wake_evt = 1'b1;
        @(negedge clk_osc);
        wake_evt = 1'b0;
        chk(core_rst == 1'b0, "R6 reset not yet set one edge after wake", core_rst, 0);
        for (int i = 0; i < OST + 20; i++) begin
            @(negedge clk_osc);
            if (core_rst) hi_cnt++;
            else if (hi_cnt > 0) break;
        end
        chk(hi_cnt == OST, "R6 wake hold length", hi_cnt, OST);
        chk(done_pulse == 1'b1, "R9 pulse after wake release", done_pulse, 1);
    endtask

    task automatic test_wake_rc();
        int c;
        int bad_rst = 0;
        int bad_pulse = 0;
        power_up(2'b11, 1'b1, 1'b1, c);
        repeat (5) @(negedge clk_osc);
        wake_evt = 1'b1;
        @(negedge clk_osc);
        wake_evt = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk_osc);
            if (core_rst) bad_rst++;
            if (done_pulse) bad_pulse++;
        end
        chk(bad_rst == 0, "R7 rc wake keeps core running", bad_rst, 0);
        chk(bad_pulse == 0, "R7 rc wake gives no pulse", bad_pulse, 0);
    endtask

    task automatic test_mclr_late();
        int c;
        power_up(2'b01, 1'b1, 1'b0, c);
        chk(c == 3000, "R8 held while mclr low", c, 3000);
        mclr_n = 1'b1;
        repeat (2) @(negedge clk_osc);
        chk(core_rst == 1'b1, "R8 still held two edges after mclr rise", core_rst, 1);
        @(negedge clk_osc);
        chk(core_rst == 1'b0, "R8 released third edge after mclr rise", core_rst, 0);
        chk(done_pulse == 1'b1, "R9 pulse on mclr release", done_pulse, 1);
        @(negedge clk_osc);
        chk(done_pulse == 1'b0, "R9 pulse ends", done_pulse, 0);
    endtask

    task automatic test_mclr_run();
        int c;
        power_up(2'b11, 1'b0, 1'b1, c);
        repeat (3) @(negedge clk_osc);
        mclr_n = 1'b0;
        repeat (3) @(negedge clk_osc);
        chk(core_rst == 1'b1, "R8 mclr low forces reset", core_rst, 1);
        repeat (10) @(negedge clk_osc);
        mclr_n = 1'b1;
        repeat (3) @(negedge clk_osc);
        chk(core_rst == 1'b0, "R8 release with no delay rerun", core_rst, 0);
    endtask

    initial begin
        test_xtal_pwrt();
        test_rc_pwrt();
        test_xtal_nopwrt();
        test_rc_nopwrt();
        test_wake_xtal();
        test_wake_rc();
        test_mclr_late();
        test_mclr_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule